// File: doc/BRIEF.md
# Supply-Fail Write-Protect Supervisor

This block supervises a battery-backed byte-wide memory from a digitized supply reading. On every clock it takes one supply sample in millivolts and a variant select. From these it decides whether the memory may be used normally, must be write-protected with its bus ignored and its data drivers floated, or must run from its backup cell. Two threshold variants are supported. The high variant allows operation above 4750 mV and must protect by 4500 mV. The low variant allows operation above 4500 mV and must protect by 4250 mV. The backup cell takes over below about 3000 mV.

Every comparison carries a hysteresis margin of 50 mV by default. Leaving protection also needs a run of consecutive good samples, 4 by default. A sticky arm flag stands for a backup cell that leaves the factory disconnected. The flag sets the first time a sample exceeds 4250 mV, and only a separate power-on reset clears it. The ordinary reset leaves it alone.

Top module: `supply_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters a protected state: `wp_o`, `hiz_o` and `in_ign_o` are 1 and `bat_sel_o` is 0 after that edge.
- R2: With `hi_var_i`=1, a sample below 4550 mV taken while operating normally sets `wp_o` to 1 at the same clock edge that captures the sample.
- R3: With `hi_var_i`=0, the release level is 4550 mV and the trip level is 4300 mV. A sample below 4300 mV taken in normal operation sets `wp_o` at the edge that captures it.
- R4: Protection is released only after 4 consecutive protected-state samples at or above the release level (4800 mV high variant, 4550 mV low variant). `wp_o` falls at the edge that captures the 4th sample, and any lower sample restarts the count.
- R5: `hiz_o` and `in_ign_o` are asserted exactly when `wp_o` is asserted.
- R6: Once armed, a protected-state sample below 2950 mV sets `bat_sel_o` at the edge that captures it. A drop taken in normal operation first goes to protection (with `bat_sel_o`=0) and reaches battery only on the next low sample.
- R7: While `bat_sel_o` is 1, a sample above 3050 mV clears it at that edge. Samples from 2950 to 3050 mV change nothing, and the block then stays protected.
- R8: After power-on reset the block is disarmed. It arms on the first sample above 4250 mV. `bat_sel_o` never asserts while the block is disarmed.
- R9: `rst_n` does not clear the arm flag, and `por_n` low clears it.
- R10: Samples at or above the trip level keep normal operation. Samples below the release level never release protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset of the state machine |
| por_n | input | 1 | Synchronous active-low power-on reset of the arm flag |
| vdd_mv_i | input | 16 | Supply sample in millivolts |
| hi_var_i | input | 1 | 1 selects the higher-threshold variant |
| wp_o | output | 1 | Write protect |
| hiz_o | output | 1 | Hold data outputs in high impedance |
| in_ign_o | output | 1 | Treat bus inputs as don't-care |
| bat_sel_o | output | 1 | Power the memory from the backup cell |

## Verification
A wrong state shows up on the flags at the very next edge. A release counter that does not restart lets `wp_o` fall early after an interrupted run of good samples. A lost arm flag shows as `bat_sel_o` staying low one sample after a deep drop that follows an ordinary reset. Hysteresis errors appear as a flag change on samples that sit within 50 mV of a threshold. Each of these is visible in the cycle that captures the offending sample.

// File: rtl/supv_pkg.sv
// Shared types for the supply supervisor.
package supv_pkg;
    // Supervisor states; all but ST_NORM are protected.
    typedef enum logic [1:0] {
        ST_FIRST = 2'd0,  // first power-up, cell not yet armed
        ST_PROT  = 2'd1,  // protected, on external supply
        ST_NORM  = 2'd2,  // full read/write operation
        ST_BATT  = 2'd3   // retention on backup cell
    } supv_state_e;
endpackage

// File: rtl/supv_limits.sv
// Threshold selector: returns the release and trip levels of the chosen
// supply variant, each already offset by the hysteresis margin.
// Assumes the levels plus margin fit in MV_W bits.
module supv_limits #(
    parameter int MV_W       = 16,
    parameter int HI_REL_MV  = 4750,
    parameter int HI_TRIP_MV = 4500,
    parameter int LO_REL_MV  = 4500,
    parameter int LO_TRIP_MV = 4250,
    parameter int HYST_MV    = 50
) (
    input  logic            hi_var_i,
    output logic [MV_W-1:0] rel_mv_o,
    output logic [MV_W-1:0] trip_mv_o
);
    localparam logic [MV_W-1:0] HI_REL  = MV_W'(HI_REL_MV + HYST_MV);
    localparam logic [MV_W-1:0] HI_TRIP = MV_W'(HI_TRIP_MV + HYST_MV);
    localparam logic [MV_W-1:0] LO_REL  = MV_W'(LO_REL_MV + HYST_MV);
    localparam logic [MV_W-1:0] LO_TRIP = MV_W'(LO_TRIP_MV + HYST_MV);

    // Pick the level pair for the active variant.
    always_comb begin
        rel_mv_o  = hi_var_i ? HI_REL  : LO_REL;
        trip_mv_o = hi_var_i ? HI_TRIP : LO_TRIP;
    end
endmodule

// File: rtl/supv_qual.sv
// Release qualifier: counts consecutive good samples while run_i is high.
// done_o is high in the cycle whose sample completes the run of QUAL_N.
// Assumes QUAL_N >= 1.
module supv_qual #(
    parameter int QUAL_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic ok_i,
    output logic done_o
);
    localparam int             CW   = $clog2(QUAL_N + 1);
    localparam logic [CW-1:0]  LAST = CW'(QUAL_N - 1);

    logic [CW-1:0] cnt;

    // Count good samples; any bad sample or leaving the state restarts.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || !ok_i)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    // Run completes when the last needed sample is good.
    always_comb done_o = run_i && ok_i && (cnt == LAST);

    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !ok_i) |=> (cnt == '0));
endmodule

// File: rtl/supv_arm.sv
// Backup-cell arm flag: a one-time latch set by the first sample above
// ARM_MV. Only por_n (synchronous, active low) clears it; the ordinary
// reset does not reach this module.
module supv_arm #(
    parameter int MV_W   = 16,
    parameter int ARM_MV = 4250
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic [MV_W-1:0] mv_i,
    output logic            arm_hit_o,
    output logic            armed_o
);
    localparam logic [MV_W-1:0] ARM_LVL = MV_W'(ARM_MV);

    // Sample qualifies for arming.
    always_comb arm_hit_o = (mv_i > ARM_LVL);

    // Sticky arm flag in the power-on domain.
    always_ff @(posedge clk) begin
        if (!por_n)
            armed_o <= 1'b0;
        else if (arm_hit_o)
            armed_o <= 1'b1;
    end

    a_r9_arm_sticky: assert property (@(posedge clk) disable iff (!por_n)
        $past(armed_o) |-> armed_o);
    a_r8_arm_cause: assert property (@(posedge clk) disable iff (!por_n)
        $rose(armed_o) |-> $past(mv_i > ARM_LVL));
endmodule

// File: rtl/supply_guard.sv
// Supply-fail supervisor for a battery-backed memory. It takes one supply
// sample per clock and drives write-protect, output-float, input-ignore
// and battery-select flags from a registered state. Protection is entered
// without condition; release needs QUAL_N consecutive good samples.
// Assumes vdd_mv_i is already synchronous to clk. rst_n and por_n are
// synchronous and active low.
module supply_guard
    import supv_pkg::*;
#(
    parameter int MV_W       = 16,
    parameter int HI_REL_MV  = 4750,
    parameter int HI_TRIP_MV = 4500,
    parameter int LO_REL_MV  = 4500,
    parameter int LO_TRIP_MV = 4250,
    parameter int BAT_MV     = 3000,
    parameter int ARM_MV     = 4250,
    parameter int HYST_MV    = 50,
    parameter int QUAL_N     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            por_n,
    input  logic [MV_W-1:0] vdd_mv_i,
    input  logic            hi_var_i,
    output logic            wp_o,
    output logic            hiz_o,
    output logic            in_ign_o,
    output logic            bat_sel_o
);
    localparam logic [MV_W-1:0] BAT_ON  = MV_W'(BAT_MV - HYST_MV);
    localparam logic [MV_W-1:0] BAT_OFF = MV_W'(BAT_MV + HYST_MV);
    localparam logic [MV_W-1:0] HI_TRIP_CHK = MV_W'(HI_TRIP_MV + HYST_MV);
    localparam logic [MV_W-1:0] LO_TRIP_CHK = MV_W'(LO_TRIP_MV + HYST_MV);

    supv_state_e     st, nxt;
    logic [MV_W-1:0] rel_mv, trip_mv;
    logic            rel_done, arm_hit, armed;

    supv_limits #(
        .MV_W(MV_W), .HI_REL_MV(HI_REL_MV), .HI_TRIP_MV(HI_TRIP_MV),
        .LO_REL_MV(LO_REL_MV), .LO_TRIP_MV(LO_TRIP_MV), .HYST_MV(HYST_MV)
    ) u_limits (
        .hi_var_i (hi_var_i),
        .rel_mv_o (rel_mv),
        .trip_mv_o(trip_mv)
    );

    supv_qual #(.QUAL_N(QUAL_N)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (st == ST_PROT),
        .ok_i  (vdd_mv_i >= rel_mv),
        .done_o(rel_done)
    );

    supv_arm #(.MV_W(MV_W), .ARM_MV(ARM_MV)) u_arm (
        .clk      (clk),
        .por_n    (por_n),
        .mv_i     (vdd_mv_i),
        .arm_hit_o(arm_hit),
        .armed_o  (armed)
    );

    // Next-state decision from the current sample.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_FIRST: if (arm_hit) nxt = ST_PROT;
            ST_PROT: begin
                if (armed && (vdd_mv_i < BAT_ON)) nxt = ST_BATT;
                else if (rel_done)                nxt = ST_NORM;
            end
            ST_NORM:  if (vdd_mv_i < trip_mv)  nxt = ST_PROT;
            ST_BATT:  if (vdd_mv_i > BAT_OFF)  nxt = ST_PROT;
            default:  nxt = ST_PROT;
        endcase
    end

    // State register; reset lands in a protected state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= armed ? ST_PROT : ST_FIRST;
        else
            st <= nxt;
    end

    // Output flags decoded from the state register.
    always_comb begin
        wp_o      = (st != ST_NORM);
        hiz_o     = (st != ST_NORM);
        in_ign_o  = (st != ST_NORM);
        bat_sel_o = (st == ST_BATT);
    end

    a_r2_trip_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_o && hi_var_i && (vdd_mv_i < HI_TRIP_CHK)) |=> wp_o);
    a_r3_trip_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_o && !hi_var_i && (vdd_mv_i < LO_TRIP_CHK)) |=> wp_o);
    a_r4_release_good: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wp_o) |-> $past(vdd_mv_i >= rel_mv));
    a_r6_bat_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bat_sel_o) |-> $past(vdd_mv_i < BAT_ON));
    a_r7_bat_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_sel_o && (vdd_mv_i > BAT_OFF)) |=> !bat_sel_o);
    a_r8_bat_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel_o |-> armed);
endmodule

// File: tb/test_supply_guard.sv
module test_supply_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [15:0] vdd_mv = 16'd0;
    logic        hi_var = 1'b1;
    logic        wp, hiz, ign, bat;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    supply_guard i_supply_guard (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .vdd_mv_i(vdd_mv),
        .hi_var_i(hi_var), .wp_o(wp), .hiz_o(hiz), .in_ign_o(ign),
        .bat_sel_o(bat)
    );

    typedef struct packed {
        logic        hi;
        logic [15:0] mv;
        logic        wp;
        logic        bat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 16'd2000, 1'b1, 1'b0, 4'd8},   // R8 unarmed, no battery
        '{1'b1, 16'd4200, 1'b1, 1'b0, 4'd8},   // R8 not above arm level
        '{1'b1, 16'd2000, 1'b1, 1'b0, 4'd8},   // R8 still unarmed
        '{1'b1, 16'd4300, 1'b1, 1'b0, 4'd8},   // R8 arms, goes protected
        '{1'b1, 16'd4900, 1'b1, 1'b0, 4'd4},   // R4 good 1
        '{1'b1, 16'd4900, 1'b1, 1'b0, 4'd4},   // R4 good 2
        '{1'b1, 16'd4790, 1'b1, 1'b0, 4'd10},  // R10 below release, restart
        '{1'b1, 16'd4900, 1'b1, 1'b0, 4'd4},   // R4 good 1
        '{1'b1, 16'd4900, 1'b1, 1'b0, 4'd4},   // R4 good 2
        '{1'b1, 16'd4900, 1'b1, 1'b0, 4'd4},   // R4 good 3
        '{1'b1, 16'd4900, 1'b0, 1'b0, 4'd4},   // R4 good 4 releases
        '{1'b1, 16'd4600, 1'b0, 1'b0, 4'd10},  // R10 held above trip
        '{1'b1, 16'd4560, 1'b0, 1'b0, 4'd10},  // R10 held above trip
        '{1'b1, 16'd4549, 1'b1, 1'b0, 4'd2},   // R2 trip
        '{1'b1, 16'd4700, 1'b1, 1'b0, 4'd10},  // R10 no release
        '{1'b1, 16'd2900, 1'b1, 1'b1, 4'd6},   // R6 battery on
        '{1'b1, 16'd3040, 1'b1, 1'b1, 4'd7},   // R7 inside band
        '{1'b1, 16'd3100, 1'b1, 1'b0, 4'd7},   // R7 battery off
        '{1'b1, 16'd2960, 1'b1, 1'b0, 4'd7},   // R7 band, no re-entry
        '{1'b0, 16'd4560, 1'b1, 1'b0, 4'd3},   // R3 low variant good 1
        '{1'b0, 16'd4560, 1'b1, 1'b0, 4'd3},
        '{1'b0, 16'd4560, 1'b1, 1'b0, 4'd3},
        '{1'b0, 16'd4560, 1'b0, 1'b0, 4'd3},   // R3 release at 4th
        '{1'b0, 16'd4310, 1'b0, 1'b0, 4'd10},  // R10 above low trip
        '{1'b0, 16'd4299, 1'b1, 1'b0, 4'd3},   // R3 low trip
        '{1'b0, 16'd4000, 1'b1, 1'b0, 4'd3},
        '{1'b0, 16'd4600, 1'b1, 1'b0, 4'd4},
        '{1'b0, 16'd4600, 1'b1, 1'b0, 4'd4},
        '{1'b0, 16'd4600, 1'b1, 1'b0, 4'd4},
        '{1'b0, 16'd4600, 1'b0, 1'b0, 4'd4},
        '{1'b0, 16'd1000, 1'b1, 1'b0, 4'd6},   // R6 protect first
        '{1'b0, 16'd1000, 1'b1, 1'b1, 4'd6},   // R6 then battery
        '{1'b0, 16'd1000, 1'b1, 1'b1, 4'd6},
        '{1'b0, 16'd3000, 1'b1, 1'b1, 4'd7}    // R7 band holds battery
    };

    task automatic chk(input int req, input logic ewp, input logic ebat);
        checks++;
        if (wp !== ewp || hiz !== ewp || ign !== ewp || bat !== ebat) begin
            failures++;
            $display("FAIL R%0d: wp=%b hiz=%b ign=%b bat=%b expected wp/hiz/ign=%b bat=%b",
                     req, wp, hiz, ign, bat, ewp, ebat);
        end
    endtask

    task automatic step(input logic hi, input logic [15:0] mv);
        @(negedge clk);
        hi_var = hi;
        vdd_mv = mv;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(1, 1'b1, 1'b0);  // R1 reset state
        @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].hi, VEC[i].mv);
            chk(int'(VEC[i].req), VEC[i].wp, VEC[i].bat);
        end

        // R9: ordinary reset during battery keeps the arm flag
        @(negedge clk);
        rst_n = 1'b0;
        vdd_mv = 16'd1000;
        @(posedge clk);
        #1;
        chk(1, 1'b1, 1'b0);  // R1 reset leaves battery, protected
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(9, 1'b1, 1'b1);  // R9 still armed, battery returns

        // R9: power-on reset clears the arm flag
        @(negedge clk);
        rst_n = 1'b0;
        por_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(1, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        por_n = 1'b1;
        @(posedge clk);
        #1;
        chk(9, 1'b1, 1'b0);  // R9 disarmed, no battery
        step(1'b0, 16'd4250);
        chk(8, 1'b1, 1'b0);  // R8 exactly arm level does not arm
        step(1'b0, 16'd1000);
        chk(8, 1'b1, 1'b0);  // R8 still no battery
        step(1'b0, 16'd4251);
        chk(8, 1'b1, 1'b0);  // R8 arms
        step(1'b0, 16'd2949);
        chk(6, 1'b1, 1'b1);  // R6 just below 2950
        step(1'b0, 16'd3050);
        chk(7, 1'b1, 1'b1);  // R7 band edge holds
        step(1'b0, 16'd3051);
        chk(7, 1'b1, 1'b0);  // R7 just above 3050

        // R5 is covered by every check: hiz and ign follow wp
        finish_run();
    end
endmodule